// File: doc/BRIEF.md
# Serial Register Port with Update Buffers

This block is a serial control port that moves whole multi-byte registers rather than single bytes. A host drops a chip select, clocks in an instruction byte carrying the direction and a register address, and then clocks the data bytes of that register. The port looks up how many bytes the addressed register holds and counts through them itself. After the last byte, the next byte on the line is taken as a fresh instruction.

Written bytes land in a bank of buffer registers, which are clocked by the serial clock. The registers that drive the parallel outputs are not touched by a write. A rising edge on the update strobe passes through a two-flop synchronizer in the sync-clock domain and is registered once. On the following sync-clock edge every buffer is copied into its active register at the same time. An abort input cuts a transfer short and sends the port back to waiting for an instruction. Bytes that finished before the abort stay in the buffers.

Top module: `ser_regport`

## Requirements
- R1: Reset (`rst` high, synchronous in each clock domain) clears every buffer and every active register to zero and holds `sdo` low.
- R2: In the instruction byte, bit 7 = 1 selects a read and bit 7 = 0 selects a write. Bits 4:0 give the register address, and bits 6:5 have no effect.
- R3: The byte count comes from the address: address 0 has 2 bytes, 1 has 4, 2 has 3, 3 has 4 and 4 has 2. Data moves most significant bit first, and the first data byte is the register's most significant byte. The byte after the last data byte is decoded as a new instruction within the same chip-select window.
- R4: A written byte goes into its buffer lane on the rising serial clock that completes it. The active registers do not change until an update.
- R5: A rising edge of `io_update` copies all buffers into the active registers on the 4th rising edge of `sync_clk`, counting the first edge that samples the strobe high as edge 1. A strobe held high gives exactly one copy.
- R6: `abort` high at a rising serial clock drops the byte in progress and returns the port to expecting an instruction. Buffer bytes already completed in that transfer are kept.
- R7: While `cs_n` is high, serial clock edges shift nothing, the port returns to expecting an instruction, and `sdo` stays low.
- R8: Addresses 5 to 31 are one-byte registers. A write to them is discarded, and a read of them returns 0x00.
- R9: `sdo` changes only on the falling serial clock. The MSB of the first read byte appears after the falling edge that follows the 8th instruction bit. `sdo` is low outside the data phase of a read.
- R10: A read returns the buffer contents, including bytes written but not yet copied by an update.
- R11: `act_regs` carries register i at bits [32*i+31 : 32*i], right-justified, with the bits above the register's byte count held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, seen in both clock domains |
| sclk | input | 1 | Serial clock; input sampled on rising edge, output driven on falling edge |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in |
| abort | input | 1 | Cancels the transfer in progress, sampled on rising `sclk` |
| sdo | output | 1 | Serial data out |
| sync_clk | input | 1 | Clock of the active-register domain |
| io_update | input | 1 | Update strobe; rising edge copies buffers to active registers |
| act_regs | output | 160 | Active registers, 32 bits per register, register 0 in the low bits |

## Verification
On every cycle, the embedded assertions check the following: chip select and abort return the sequencer to the instruction phase; the byte index stays below the register's byte count; a write to an unlisted address leaves the buffers unchanged; `sdo` stays quiet outside read data; the active registers hold between copies and take the buffer values on a copy; and a copy request lasts one cycle. Other properties depend on whole transactions, so only the bench scenarios show them. These are the byte order and byte counts of each register, the exact sync edge on which a copy lands, which bytes survive a mid-byte or mid-register abort, the recovery after chip select goes high, and that reads see buffer rather than active contents.

// File: rtl/ser_regport_pkg.sv
package ser_regport_pkg;

    localparam int ADDR_W    = 5;
    localparam int BYTE_W    = 8;
    localparam int LANE_W    = 2;
    localparam int CNT_W     = 3;
    localparam int REG_W     = 32;
    localparam int TBL_REGS  = 5;
    localparam int POS_W     = LANE_W + 3;

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_t;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  nbytes;
    } instr_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [LANE_W-1:0] lane;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    // Byte count per register address; anything unlisted counts as one byte.
    function automatic logic [CNT_W-1:0] reg_len(input logic [ADDR_W-1:0] a);
        logic [CNT_W-1:0] n;
        case (a)
            5'd0:    n = 3'd2;
            5'd1:    n = 3'd4;
            5'd2:    n = 3'd3;
            5'd3:    n = 3'd4;
            5'd4:    n = 3'd2;
            default: n = 3'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sp_serial_front.sv
module sp_serial_front
    import ser_regport_pkg::*;
(
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              abort,
    input  logic              sdi,
    input  logic              rd_bit,
    output wr_req_t           wr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [POS_W-1:0]  rd_pos,
    output logic              sdo
);

    phase_t              phase;
    logic [CNT_W-1:0]    bit_cnt;
    logic [LANE_W-1:0]   byte_idx;
    logic [BYTE_W-2:0]   shreg;
    instr_t              cur;

    logic [BYTE_W-1:0]   sh_next;
    logic                byte_done;
    logic                last_byte;
    logic [LANE_W-1:0]   lane;
    logic                restart;

    assign sh_next   = {shreg, sdi};
    assign byte_done = (bit_cnt == 3'd7);
    assign last_byte = ({1'b0, byte_idx} == (cur.nbytes - 3'd1));
    assign lane      = LANE_W'(cur.nbytes - 3'd1 - {1'b0, byte_idx});
    assign restart   = cs_n || abort;

    always_comb begin
        wr.en   = !restart && (phase == PH_DATA) && !cur.rd && byte_done;
        wr.addr = cur.addr;
        wr.lane = lane;
        wr.data = sh_next;
    end

    assign rd_addr = cur.addr;
    assign rd_pos  = {lane, 3'd7 - bit_cnt};

    always_ff @(posedge sclk) begin
        if (rst) begin
            phase    <= PH_INSTR;
            bit_cnt  <= '0;
            byte_idx <= '0;
            shreg    <= '0;
            cur      <= '0;
        end else if (restart) begin
            phase    <= PH_INSTR;
            bit_cnt  <= '0;
            byte_idx <= '0;
            shreg    <= '0;
        end else begin
            shreg   <= sh_next[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (byte_done) begin
                if (phase == PH_INSTR) begin
                    cur.rd     <= sh_next[7];
                    cur.addr   <= sh_next[ADDR_W-1:0];
                    cur.nbytes <= reg_len(sh_next[ADDR_W-1:0]);
                    phase      <= PH_DATA;
                    byte_idx   <= '0;
                end else if (last_byte) begin
                    phase    <= PH_INSTR;
                    byte_idx <= '0;
                end else begin
                    byte_idx <= byte_idx + 2'd1;
                end
            end
        end
    end

    always_ff @(negedge sclk) begin
        if (rst || cs_n) begin
            sdo <= 1'b0;
        end else begin
            sdo <= (phase == PH_DATA && cur.rd) ? rd_bit : 1'b0;
        end
    end

    a_r7_cs_restart: assert property (@(posedge sclk) disable iff (rst)
        cs_n |=> (phase == PH_INSTR && bit_cnt == 3'd0));

    a_r6_abort_restart: assert property (@(posedge sclk) disable iff (rst)
        abort |=> (phase == PH_INSTR && bit_cnt == 3'd0));

    a_r3_byte_bound: assert property (@(posedge sclk) disable iff (rst)
        (phase == PH_DATA) |-> ({1'b0, byte_idx} < cur.nbytes));

    a_r9_sdo_quiet: assert property (@(negedge sclk) disable iff (rst)
        (cs_n || phase != PH_DATA || !cur.rd) |=> !sdo);

endmodule

// File: rtl/sp_buf_bank.sv
module sp_buf_bank
    import ser_regport_pkg::*;
#(
    parameter int NUM_REGS = TBL_REGS,
    parameter int RW       = REG_W
) (
    input  logic                   rst,
    input  logic                   sclk,
    input  wr_req_t                wr,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [POS_W-1:0]       rd_pos,
    output logic                   rd_bit,
    output logic [NUM_REGS*RW-1:0] buf_flat
);

    logic [RW-1:0] bregs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
        localparam logic [CNT_W-1:0]  MY_LEN  = reg_len(MY_ADDR);

        always_ff @(posedge sclk) begin
            if (rst) begin
                bregs[g] <= '0;
            end else if (wr.en && wr.addr == MY_ADDR && {1'b0, wr.lane} < MY_LEN) begin
                bregs[g][{wr.lane, 3'b000} +: BYTE_W] <= wr.data;
            end
        end

        assign buf_flat[g*RW +: RW] = bregs[g];
    end

    always_comb begin
        rd_bit = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_bit = bregs[i][rd_pos];
            end
        end
    end

    a_r8_unlisted_drop: assert property (@(posedge sclk) disable iff (rst)
        (wr.en && wr.addr >= ADDR_W'(NUM_REGS)) |=> $stable(buf_flat));

endmodule

// File: rtl/sp_upd_sync.sv
module sp_upd_sync (
    input  logic rst,
    input  logic sync_clk,
    input  logic io_update,
    output logic copy
);

    logic s1, s2, s3, pend;

    always_ff @(posedge sync_clk) begin
        if (rst) begin
            s1   <= 1'b0;
            s2   <= 1'b0;
            s3   <= 1'b0;
            pend <= 1'b0;
        end else begin
            s1   <= io_update;
            s2   <= s1;
            s3   <= s2;
            pend <= s2 && !s3;
        end
    end

    assign copy = pend;

    a_r5_single_copy: assert property (@(posedge sync_clk) disable iff (rst)
        copy |=> !copy);

endmodule

// File: rtl/sp_active_bank.sv
module sp_active_bank #(
    parameter int W = 160
) (
    input  logic         rst,
    input  logic         sync_clk,
    input  logic         copy,
    input  logic [W-1:0] buf_flat,
    output logic [W-1:0] act
);

    always_ff @(posedge sync_clk) begin
        if (rst) begin
            act <= '0;
        end else if (copy) begin
            act <= buf_flat;
        end
    end

    a_r4_hold: assert property (@(posedge sync_clk) disable iff (rst)
        !copy |=> $stable(act));

    a_r5_copy_value: assert property (@(posedge sync_clk) disable iff (rst)
        copy |=> (act == $past(buf_flat)));

endmodule

// File: rtl/ser_regport.sv
module ser_regport
    import ser_regport_pkg::*;
#(
    parameter int NUM_REGS = TBL_REGS,
    parameter int RW       = REG_W
) (
    input  logic                   rst,
    input  logic                   sclk,
    input  logic                   cs_n,
    input  logic                   sdi,
    input  logic                   abort,
    output logic                   sdo,
    input  logic                   sync_clk,
    input  logic                   io_update,
    output logic [NUM_REGS*RW-1:0] act_regs
);

    localparam int ACT_W = NUM_REGS * RW;

    wr_req_t             wr;
    logic [ADDR_W-1:0]   rd_addr;
    logic [POS_W-1:0]    rd_pos;
    logic                rd_bit;
    logic [ACT_W-1:0]    buf_flat;
    logic                copy;

    sp_serial_front i_front (
        .rst     (rst),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .abort   (abort),
        .sdi     (sdi),
        .rd_bit  (rd_bit),
        .wr      (wr),
        .rd_addr (rd_addr),
        .rd_pos  (rd_pos),
        .sdo     (sdo)
    );

    sp_buf_bank #(.NUM_REGS(NUM_REGS), .RW(RW)) i_bufs (
        .rst      (rst),
        .sclk     (sclk),
        .wr       (wr),
        .rd_addr  (rd_addr),
        .rd_pos   (rd_pos),
        .rd_bit   (rd_bit),
        .buf_flat (buf_flat)
    );

    sp_upd_sync i_sync (
        .rst       (rst),
        .sync_clk  (sync_clk),
        .io_update (io_update),
        .copy      (copy)
    );

    sp_active_bank #(.W(ACT_W)) i_act (
        .rst      (rst),
        .sync_clk (sync_clk),
        .copy     (copy),
        .buf_flat (buf_flat),
        .act      (act_regs)
    );

endmodule

// File: tb/test_ser_regport.sv
`timescale 1ns/1ps
module test_ser_regport;

    logic         rst = 1'b1;
    logic         sclk = 1'b0;
    logic         cs_n = 1'b1;
    logic         sdi = 1'b0;
    logic         abort = 1'b0;
    logic         sdo;
    logic         sync_clk = 1'b0;
    logic         io_update = 1'b0;
    logic [159:0] act_regs;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit         mon_en = 0;
    logic [7:0] cap;
    int         ncap = 0;

    ser_regport i_ser_regport (
        .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .abort(abort),
        .sdo(sdo), .sync_clk(sync_clk), .io_update(io_update), .act_regs(act_regs)
    );

    always #2 sync_clk = ~sync_clk;

    function automatic logic [31:0] act_of(input int i);
        return act_regs[i*32 +: 32];
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Monitor: assembles read bytes from sdo and compares against the scoreboard.
    always @(posedge sclk) begin
        if (mon_en) begin
            cap = {cap[6:0], sdo};
            ncap++;
            if (ncap == 8) begin
                ncap = 0;
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL unexpected read byte: actual=%h expected=none", cap);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (cap !== e) begin
                        bad++;
                        $display("FAIL %s: actual=%h expected=%h", t, cap, e);
                    end
                end
            end
        end
    end

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            sdi = b[i];
            #10 sclk = 1'b1;
            #10 sclk = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        #10;
    endtask

    task automatic cs_hi();
        #10 cs_n = 1'b1;
        #10;
    endtask

    task automatic wr_reg(input logic [4:0] a, input int n, input logic [31:0] v,
                          input logic [1:0] fl = 2'b00);
        send_byte({1'b0, fl, a});
        for (int k = n - 1; k >= 0; k--) send_byte(v[k*8 +: 8]);
    endtask

    // Driver: pushes the expected bytes, MSB byte first, then clocks them out.
    task automatic rd_reg(input logic [4:0] a, input int n, input logic [31:0] v,
                          input string tag, input logic [1:0] fl = 2'b00);
        send_byte({1'b1, fl, a});
        for (int k = n - 1; k >= 0; k--) begin
            exp_q.push_back(v[k*8 +: 8]);
            tag_q.push_back(tag);
        end
        mon_en = 1;
        for (int k = 0; k < n; k++) send_byte(8'h00);
        mon_en = 0;
    endtask

    task automatic abort_pulse();
        abort = 1'b1;
        #10 sclk = 1'b1;
        #10 sclk = 1'b0;
        abort = 1'b0;
    endtask

    task automatic do_update();
        @(negedge sync_clk) io_update = 1'b1;
        repeat (5) @(negedge sync_clk);
        io_update = 1'b0;
        repeat (3) @(negedge sync_clk);
    endtask

    initial begin
        repeat (100000) @(posedge sync_clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            #10 sclk = 1'b1;
            #10 sclk = 1'b0;
        end
        repeat (4) @(negedge sync_clk);
        rst = 1'b0;
        repeat (2) @(negedge sync_clk);

        // R1: reset state
        for (int i = 0; i < 5; i++) check("R1 active reg zero after reset", act_of(i), 32'h0);
        check("R1 sdo low after reset", {31'b0, sdo}, 32'h0);
        cs_lo();
        rd_reg(5'd1, 4, 32'h0, "R1 buffer zero after reset");
        cs_hi();

        // R3 / R10: back-to-back whole-register transfers, read sees buffers
        cs_lo();
        wr_reg(5'd0, 2, 32'h1357);
        wr_reg(5'd1, 4, 32'hA1B2C3D4);
        wr_reg(5'd2, 3, 32'h5A6B7C);
        rd_reg(5'd1, 4, 32'hA1B2C3D4, "R3 R10 4-byte read back");
        rd_reg(5'd2, 3, 32'h5A6B7C, "R3 R10 3-byte read back");
        rd_reg(5'd0, 2, 32'h1357, "R3 R10 2-byte read back");
        cs_hi();

        // R9: sdo stays low during a write data phase
        cs_lo();
        send_byte(8'h03);
        check("R9 sdo low after write instruction", {31'b0, sdo}, 32'h0);
        send_byte(8'h0F); send_byte(8'h1E);
        check("R9 sdo low mid write", {31'b0, sdo}, 32'h0);
        send_byte(8'h2D); send_byte(8'h3C);
        cs_hi();

        // R4: active registers untouched by writes
        check("R4 act1 unchanged before update", act_of(1), 32'h0);
        check("R4 act3 unchanged before update", act_of(3), 32'h0);

        // R5: copy lands on the 4th sync edge
        @(negedge sync_clk) io_update = 1'b1;
        repeat (3) @(posedge sync_clk);
        @(negedge sync_clk);
        check("R5 no copy after 3rd edge", act_of(1), 32'h0);
        @(negedge sync_clk);
        check("R5 copy after 4th edge", act_of(1), 32'hA1B2C3D4);
        check("R5 R11 act0", act_of(0), 32'h1357);
        check("R5 R11 act2", act_of(2), 32'h005A6B7C);
        check("R5 R11 act3", act_of(3), 32'h0F1E2D3C);

        // R5: strobe held high gives one copy only; R2: bits 6:5 ignored
        cs_lo();
        wr_reg(5'd4, 2, 32'h9ABC, 2'b11);
        cs_hi();
        repeat (8) @(negedge sync_clk);
        check("R5 held strobe gives single copy", act_of(4), 32'h0);
        io_update = 1'b0;
        repeat (3) @(negedge sync_clk);
        cs_lo();
        rd_reg(5'd4, 2, 32'h9ABC, "R2 flag bits ignored", 2'b10);
        cs_hi();
        do_update();
        check("R11 act4 right-justified", act_of(4), 32'h00009ABC);

        // R6: abort keeps completed bytes, drops a partial byte
        cs_lo();
        send_byte(8'h01); send_byte(8'h11); send_byte(8'h22);
        abort_pulse();
        rd_reg(5'd1, 4, 32'h1122C3D4, "R6 abort after two bytes");
        send_byte(8'h03); send_byte(8'hFF);
        send_bits(8'hF0, 4);
        abort_pulse();
        rd_reg(5'd3, 4, 32'hFF1E2D3C, "R6 abort mid byte");
        cs_hi();
        check("R4 act1 still old after abort writes", act_of(1), 32'hA1B2C3D4);

        // R7: chip select high restarts and masks sclk
        cs_lo();
        send_byte(8'h00); send_byte(8'h77);
        cs_hi();
        check("R7 sdo low with cs_n high", {31'b0, sdo}, 32'h0);
        sdi = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #10 sclk = 1'b1;
            #10 sclk = 1'b0;
        end
        check("R7 sdo low while sclk toggles deselected", {31'b0, sdo}, 32'h0);
        cs_lo();
        rd_reg(5'd0, 2, 32'h7757, "R7 restart after cs_n high");
        cs_hi();

        // R8: unlisted addresses are single discarded bytes, read as zero
        cs_lo();
        wr_reg(5'd9, 1, 32'hEE);
        rd_reg(5'd9, 1, 32'h0, "R8 unlisted read zero");
        rd_reg(5'd0, 2, 32'h7757, "R8 instruction after single byte");
        wr_reg(5'd31, 1, 32'h55);
        rd_reg(5'd31, 1, 32'h0, "R8 top address read zero");
        wr_reg(5'd2, 3, 32'hFFFFFF);
        cs_hi();
        do_update();
        check("R8 act0 after update", act_of(0), 32'h7757);
        check("R8 act1 after update", act_of(1), 32'h1122C3D4);
        check("R8 act3 after update", act_of(3), 32'hFF1E2D3C);
        check("R8 act4 after update", act_of(4), 32'h9ABC);
        check("R11 act2 upper byte zero", act_of(2), 32'h00FFFFFF);

        #40;
        check("scoreboard drained", exp_q.size(), 32'h0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule